// File: doc/BRIEF.md
# Multi-mode control pin decoder

This block gives one external active-low pin three possible jobs and picks the job from a 2-bit mode field in a configuration register. The pin can work as a hard reset request, as a level-and-edge divider synchronization request, or as a full power-down request. The decode for reset and power-down is combinational from the raw pin, so a low pin takes effect without waiting for a clock. Divider synchronization goes through a two-flop synchronizer and is timed on the fast clock.

The block contains a small two-level register model. Writes go to a staging bank, and a commit strobe copies the whole staging bank into the live bank that drives the chip. The mode field itself is stored in the live bank. A hard reset from the pin reloads both banks with their default values. A power-down leaves both banks as they are, so the chip comes back with the settings it had before. When the pin rises, a sync pulse follows, whatever the mode. This includes the release of reset.

Top module: `ctl_pin_decoder`

## Requirements
- R1: After the synchronous `rst`, all three request outputs are low and every register holds its default. Register i holds (0x15*(i+1)) mod 256. The mode register (index 3) holds 0x00, which selects reset mode.
- R2: The mode field is bits [6:5] of register 3. With mode 00 and `pin_n` low, `hard_rst_req` goes high at once, with no clock edge needed. Both the staging bank and the live bank are reloaded with their defaults for as long as the pin stays low.
- R3: Mode 10 behaves exactly like mode 00.
- R4: Each rising edge of `pin_n` sets `sync_req` high after the third rising clock edge, counted from the pin change. Outside sync mode this is a pulse one clock cycle wide.
- R5: With mode 01, a low `pin_n` holds `sync_req` high from the third clock edge after the fall until the pulse that follows release. It never raises `hard_rst_req` or `pwrdn_req`, and it leaves the registers unchanged.
- R6: With mode 11, a low `pin_n` raises `pwrdn_req` at once, with no clock edge needed, and `hard_rst_req` stays low.
- R7: When power-down is left, the live registers still hold the values they had before it.
- R8: While `pwrdn_req` is high, staging writes and commits are ignored.
- R9: A staging write does not change the live bank. A commit copies every staging register into the live bank.
- R10: `rd_data` shows the live register at `rd_addr` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high system reset |
| pin_n | input | 1 | External active-low control pin |
| wr_en | input | 1 | Staging register write strobe |
| wr_addr | input | AW | Staging register index |
| wr_data | input | DW | Staging write data |
| commit | input | 1 | Copy staging bank into live bank |
| rd_addr | input | AW | Live register index to read |
| rd_data | output | DW | Registered live register contents |
| hard_rst_req | output | 1 | Asynchronous hard reset request |
| sync_req | output | 1 | Divider synchronization request |
| pwrdn_req | output | 1 | Asynchronous full power-down request |

## Verification
The hardest case to reach is a reset-mode pin assertion that lands while the staging bank holds an edited value that has not been committed. Only a later commit can show that the staging bank was reloaded and not just the live bank. The stimulus first commits one value, then writes a different value to staging only, pulls the pin low, and then reads the live bank both before and after a fresh commit. Power-down is checked the same way: a write and a commit are attempted during power-down, and a commit after release shows whether they were discarded.

// File: rtl/cpd_pkg.sv
package cpd_pkg;
  typedef enum logic [1:0] {
    M_RESET = 2'b00,
    M_SYNC  = 2'b01,
    M_RSVD  = 2'b10,
    M_PWRDN = 2'b11
  } pin_mode_e;

  // Default contents: multiples of 0x15, mode register zero (reset mode).
  function automatic logic [31:0] reg_default(input int idx, input int mode_reg);
    if (idx == mode_reg) return 32'h0;
    return 32'(idx + 1) * 32'h15;
  endfunction
endpackage

// File: rtl/pin_sync_edge.sv
module pin_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic pin_s,
  output logic rise
);
  logic [STAGES-1:0] shreg;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '1;
      prev  <= 1'b1;
    end else begin
      shreg <= {shreg[STAGES-2:0], pin_n};
      prev  <= shreg[STAGES-1];
    end
  end

  assign pin_s = shreg[STAGES-1];
  assign rise  = shreg[STAGES-1] & ~prev;
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
  import cpd_pkg::*;
#(
  parameter int NREG     = 4,
  parameter int DW       = 8,
  parameter int MODE_REG = 3,
  parameter int MODE_LSB = 5,
  parameter int AW       = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             hold,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             commit,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data,
  output logic [NREG*DW-1:0] live_flat,
  output logic [1:0]       mode
);
  logic [DW-1:0] stage [NREG];
  logic [DW-1:0] live  [NREG];

  // clr is the pin-driven hard reset: asynchronous reload of both banks
  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      for (int i = 0; i < NREG; i++) begin
        stage[i] <= DW'(reg_default(i, MODE_REG));
        live[i]  <= DW'(reg_default(i, MODE_REG));
      end
    end else if (rst) begin
      for (int i = 0; i < NREG; i++) begin
        stage[i] <= DW'(reg_default(i, MODE_REG));
        live[i]  <= DW'(reg_default(i, MODE_REG));
      end
    end else if (!hold) begin
      if (wr_en && (int'(wr_addr) < NREG)) stage[wr_addr] <= wr_data;
      if (commit) begin
        for (int i = 0; i < NREG; i++) live[i] <= stage[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (int'(rd_addr) < NREG) rd_data <= live[rd_addr];
    else rd_data <= '0;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign live_flat[g*DW +: DW] = live[g];
  end

  assign mode = live[MODE_REG][MODE_LSB +: 2];
endmodule

// File: rtl/pin_mode_decode.sv
module pin_mode_decode
  import cpd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_n,
  input  logic       pin_s,
  input  logic       rise,
  input  logic [1:0] mode,
  output logic       hard_rst_req,
  output logic       pwrdn_req,
  output logic       sync_req
);
  logic is_rst_mode;

  // Reserved code decodes as reset mode
  assign is_rst_mode  = (mode == M_RESET) || (mode == M_RSVD);
  assign hard_rst_req = ~pin_n & is_rst_mode;
  assign pwrdn_req    = ~pin_n & (mode == M_PWRDN);

  // Edge pulse in every mode; level hold only in sync mode
  always_ff @(posedge clk) begin
    if (rst) sync_req <= 1'b0;
    else     sync_req <= rise | ((mode == M_SYNC) & ~pin_s);
  end
endmodule

// File: rtl/ctl_pin_decoder.sv
module ctl_pin_decoder #(
  parameter int NREG        = 4,
  parameter int DW          = 8,
  parameter int MODE_REG    = 3,
  parameter int MODE_LSB    = 5,
  parameter int SYNC_STAGES = 2,
  parameter int AW          = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pin_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          commit,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          hard_rst_req,
  output logic          sync_req,
  output logic          pwrdn_req
);
  logic                 pin_s;
  logic                 rise;
  logic [1:0]           live_mode;
  logic [NREG*DW-1:0]   live_flat;

  pin_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .pin_n (pin_n),
    .pin_s (pin_s),
    .rise  (rise)
  );

  cfg_bank #(
    .NREG(NREG), .DW(DW), .MODE_REG(MODE_REG), .MODE_LSB(MODE_LSB), .AW(AW)
  ) u_bank (
    .clk       (clk),
    .rst       (rst),
    .clr       (hard_rst_req),
    .hold      (pwrdn_req),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .commit    (commit),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .live_flat (live_flat),
    .mode      (live_mode)
  );

  pin_mode_decode u_dec (
    .clk          (clk),
    .rst          (rst),
    .pin_n        (pin_n),
    .pin_s        (pin_s),
    .rise         (rise),
    .mode         (live_mode),
    .hard_rst_req (hard_rst_req),
    .pwrdn_req    (pwrdn_req),
    .sync_req     (sync_req)
  );
endmodule

// File: rtl/ctl_pin_decoder_chk.sv
module ctl_pin_decoder_chk #(
  parameter int LW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    mode,
  input logic          hard_rst_req,
  input logic          sync_req,
  input logic          pwrdn_req,
  input logic [LW-1:0] live_flat
);
  // R2: while the pin resets the chip, the live mode is the default
  p_rst_reload_r2: assert property (@(posedge clk) disable iff (rst)
    hard_rst_req |-> (mode == 2'b00));

  // R6: reset and power-down requests never coexist
  p_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(hard_rst_req && pwrdn_req));

  // R5: sync mode never raises reset or power-down
  p_sync_only_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01) |-> (!hard_rst_req && !pwrdn_req));

  // R4: outside sync mode the request is one cycle wide
  p_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(sync_req) && mode != 2'b01) |=> (!sync_req || mode == 2'b01));

  // R7, R8: live bank frozen while power-down persists
  p_pd_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (pwrdn_req && $past(pwrdn_req)) |-> $stable(live_flat));
endmodule

bind ctl_pin_decoder ctl_pin_decoder_chk #(.LW(NREG*DW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .mode         (live_mode),
  .hard_rst_req (hard_rst_req),
  .sync_req     (sync_req),
  .pwrdn_req    (pwrdn_req),
  .live_flat    (live_flat)
);

// File: tb/test_ctl_pin_decoder.sv
module test_ctl_pin_decoder;
  localparam int NREG = 4;
  localparam int DW   = 8;
  localparam int AW   = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pin_n = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          commit = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          hard_rst_req, sync_req, pwrdn_req;

  int nchk = 0;
  int nfail = 0;

  always #5 clk = ~clk;

  ctl_pin_decoder i_ctl_pin_decoder (
    .clk(clk), .rst(rst), .pin_n(pin_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit(commit), .rd_addr(rd_addr), .rd_data(rd_data),
    .hard_rst_req(hard_rst_req), .sync_req(sync_req), .pwrdn_req(pwrdn_req)
  );

  // {mode[1:0], pin, exp_hard_rst, exp_pwrdn}
  localparam logic [4:0] VEC [8] = '{
    5'b00_1_0_0, 5'b00_0_1_0, 5'b01_1_0_0, 5'b01_0_0_0,
    5'b10_1_0_0, 5'b10_0_1_0, 5'b11_1_0_0, 5'b11_0_0_1
  };

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic cmt();
    @(negedge clk); commit = 1'b1;
    @(negedge clk); commit = 1'b0;
  endtask

  task automatic rd(input int a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk); rd_addr = AW'(a);
    @(negedge clk); chk(32'(rd_data), 32'(exp), tag);
  endtask

  task automatic set_mode(input logic [1:0] m);
    wr(3, DW'({m, 5'b0}));
    cmt();
  endtask

  function automatic logic [DW-1:0] dflt(input int i);
    return (i == 3) ? 8'h00 : DW'((i + 1) * 8'h15);
  endfunction

  initial begin
    #1_000_000;
    nchk++; nfail++;
    $display("FAIL watchdog got timeout exp completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(32'({hard_rst_req, sync_req, pwrdn_req}), 0, "R1 outputs");
    for (int i = 0; i < NREG; i++) rd(i, dflt(i), "R1 default");

    // R9: staging vs live, R10 read latency
    wr(0, 8'hA5);
    rd(0, 8'h15, "R9 live untouched");
    cmt();
    rd(0, 8'hA5, "R9 after commit");
    @(negedge clk); rd_addr = 2'd1;
    @(posedge clk); #1;
    chk(32'(rd_data), 32'h2A, "R10 one cycle read");

    // Decode table walk (R2 R3 R5 R6)
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); pin_n = 1'b1;
      repeat (6) @(negedge clk);
      set_mode(VEC[k][4:3]);
      @(negedge clk); pin_n = VEC[k][2];
      #1;
      chk(32'(hard_rst_req), 32'(VEC[k][1]), "R2 R3 R5 R6 table hard_rst");
      chk(32'(pwrdn_req),    32'(VEC[k][0]), "R2 R3 R5 R6 table pwrdn");
      repeat (3) @(negedge clk);
    end
    @(negedge clk); pin_n = 1'b1;
    repeat (6) @(negedge clk);

    // R2: reset reloads staging and live; R4 sync after release
    set_mode(2'b00);
    wr(1, 8'h77); cmt();
    wr(1, 8'h99);
    @(negedge clk); pin_n = 1'b0;
    #1 chk(32'(hard_rst_req), 1, "R2 async assert");
    repeat (4) @(negedge clk);
    pin_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(32'(sync_req), 1, "R4 pulse after reset release");
    @(negedge clk);
    chk(32'(sync_req), 0, "R4 pulse width");
    rd(1, 8'h2A, "R2 live reloaded");
    cmt();
    rd(1, 8'h2A, "R2 staging reloaded");

    // R3: reserved code acts as reset
    wr(2, 8'h11);
    set_mode(2'b10);
    rd(2, 8'h11, "R3 setup");
    @(negedge clk); pin_n = 1'b0;
    #1 chk(32'(hard_rst_req), 1, "R3 reserved resets");
    repeat (4) @(negedge clk);
    pin_n = 1'b1;
    repeat (5) @(negedge clk);
    rd(2, 8'h3F, "R3 reg reloaded");
    rd(3, 8'h00, "R3 mode back to reset");

    // R5: sync mode level hold
    wr(0, 8'h5A);
    set_mode(2'b01);
    @(negedge clk); pin_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(32'(sync_req), 1, "R5 level active");
    chk(32'({hard_rst_req, pwrdn_req}), 0, "R5 no reset or pwrdn");
    repeat (4) @(negedge clk);
    chk(32'(sync_req), 1, "R5 level held");
    rd(0, 8'h5A, "R5 regs unchanged");
    @(negedge clk); pin_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(32'(sync_req), 1, "R5 R4 pulse at release");
    @(negedge clk);
    chk(32'(sync_req), 0, "R5 released");

    // R6 R7 R8: power-down
    wr(1, 8'h3C);
    set_mode(2'b11);
    @(negedge clk); pin_n = 1'b0;
    #1 chk(32'(pwrdn_req), 1, "R6 async pwrdn");
    chk(32'(hard_rst_req), 0, "R6 no hard reset");
    repeat (3) @(negedge clk);
    wr(1, 8'hFF);
    cmt();
    @(negedge clk); pin_n = 1'b1;
    #1 chk(32'(pwrdn_req), 0, "R6 release");
    repeat (2) @(negedge clk);
    @(negedge clk);
    chk(32'(sync_req), 1, "R4 pulse after pwrdn release");
    rd(1, 8'h3C, "R7 settings kept");
    rd(3, 8'h60, "R7 mode kept");
    cmt();
    rd(1, 8'h3C, "R8 write ignored");

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule